// File: doc/BRIEF.md
# Timed Display Power Sequencer

This block walks a display controller through its power-up and power-down register programs. It does not talk to the panel directly. It drives a simple register-write command port: an 8-bit register index, a 16-bit value, and a one-cycle write strobe. A downstream serial access master carries out each write and answers with a done pulse, which may carry an error flag.

Between certain writes the controller needs time for its supply rails to settle. The block inserts these pauses with a countdown timer. The timer's lengths come from a clock-frequency parameter, and each pause is rounded up to whole cycles.

Two request inputs select the target state, on or off. A request that matches the present power state is dropped. Requests that arrive while a program is running are dropped as well. The power-state flag changes only when a program finishes and none of its writes reported an error.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, `busy`, `wr_stb` and `pwr_on` are all 0.
- R2: A power-up request while off issues nine writes as (index, value) pairs: (0x10,0x0000), (0x11,0x0000), (0x12,0x0000), (0x13,0x0000), (0x56,0x080F), (0x10,0x4240), (0x11,0x0000), (0x12,0x0014), (0x13,0x1319). When it completes without error, `pwr_on` becomes 1.
- R3: A power-down request while on issues only the first four writes of R2 (the zeroing pass). When it completes without error, `pwr_on` becomes 0.
- R4: After the done pulse of a write to index 0x10, the next strobe rises exactly NS+1 cycles after the cycle in which `wr_done` is high, where NS = ceil(10 * CLK_HZ / 1000).
- R5: After the done pulse of a write to index 0x12 or 0x13, the gap is NL+1 cycles, where NL = ceil(40 * CLK_HZ / 1000). This gap applies both to the next strobe and, after the final write, to the cycle in which `busy` falls and `pwr_on` updates.
- R6: After the done pulse of a write to index 0x11 or 0x56, the next strobe follows in the very next cycle.
- R7: A power-up request while on, or a power-down request while off, produces no strobe and leaves `busy` at 0.
- R8: When both requests are high together, power-down wins. While on, this starts the R3 program. While off, nothing happens.
- R9: Requests that arrive while `busy` is 1 have no effect on the running program or on the final state.
- R10: A `wr_err` flag seen with any `wr_done` does not stop the program: all of its writes are still issued. `pwr_on` then keeps its previous value.
- R11: `wr_stb` is high for one cycle per write and only while `busy`. `reg_idx` and `reg_val` stay constant from the strobe until the matching `wr_done`.
- R12: `pwr_on` changes only in the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_on | input | 1 | Request to power the display up |
| req_off | input | 1 | Request to power the display down |
| wr_done | input | 1 | One-cycle completion pulse from the write master |
| wr_err | input | 1 | Error flag, valid together with `wr_done` |
| reg_idx | output | 8 | Register index of the current write |
| reg_val | output | 16 | Value of the current write |
| wr_stb | output | 1 | One-cycle write command strobe |
| busy | output | 1 | A program is running |
| pwr_on | output | 1 | Current display power state |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a long settling pause. It must not disturb the step counter or the final flag. The bench waits until `busy` is high and then pulses the opposite request. The scoreboard still expects exactly the original program, plus its settling gaps, measured cycle by cycle from each done pulse.

A second hard case is an error that occurs partway through a program. The bench's write slave raises `wr_err` on one chosen write. The scoreboard then expects every remaining write to be issued and the flag to stay where it was.

// File: rtl/disp_pwr_pkg.sv
package disp_pwr_pkg;

  // Settling pause that follows a write once its done pulse arrives.
  typedef enum logic [1:0] {
    GAP_NONE  = 2'd0,
    GAP_SHORT = 2'd1,
    GAP_LONG  = 2'd2
  } gap_e;

  typedef struct packed {
    logic [7:0]  idx;
    logic [15:0] val;
    gap_e        gap;
  } step_t;

  localparam int STEP_W      = 4;
  localparam int LAST_UP_STEP = 8;  // nine writes for power-up
  localparam int LAST_DN_STEP = 3;  // zeroing pass only for power-down

  // Round a millisecond interval up to whole clock cycles.
  function automatic longint ms_to_cyc(longint hz, longint ms);
    return (hz * ms + 64'd999) / 64'd1000;
  endfunction

endpackage

// File: rtl/disp_pwr_steps.sv
module disp_pwr_steps
  import disp_pwr_pkg::*;
(
  input  logic [STEP_W-1:0] step_idx,
  output step_t             step
);

  // Steps 0..3 form the zeroing pass, shared by both programs.
  always_comb begin
    unique case (step_idx)
      4'd0:    step = '{idx: 8'h10, val: 16'h0000, gap: GAP_SHORT};
      4'd1:    step = '{idx: 8'h11, val: 16'h0000, gap: GAP_NONE};
      4'd2:    step = '{idx: 8'h12, val: 16'h0000, gap: GAP_LONG};
      4'd3:    step = '{idx: 8'h13, val: 16'h0000, gap: GAP_LONG};
      4'd4:    step = '{idx: 8'h56, val: 16'h080F, gap: GAP_NONE};
      4'd5:    step = '{idx: 8'h10, val: 16'h4240, gap: GAP_SHORT};
      4'd6:    step = '{idx: 8'h11, val: 16'h0000, gap: GAP_NONE};
      4'd7:    step = '{idx: 8'h12, val: 16'h0014, gap: GAP_LONG};
      4'd8:    step = '{idx: 8'h13, val: 16'h1319, gap: GAP_LONG};
      default: step = '{idx: 8'h00, val: 16'h0000, gap: GAP_NONE};
    endcase
  end

endmodule

// File: rtl/disp_pwr_timer.sv
module disp_pwr_timer
  import disp_pwr_pkg::*;
#(
  parameter longint CLK_HZ   = 200_000_000,
  parameter longint SHORT_MS = 10,
  parameter longint LONG_MS  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  gap_e gap,
  output logic expired
);

  localparam longint SHORT_CYC = ms_to_cyc(CLK_HZ, SHORT_MS);
  localparam longint LONG_CYC  = ms_to_cyc(CLK_HZ, LONG_MS);
  localparam int     CW        = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = (gap == GAP_LONG) ? LONG_LD : SHORT_LD;
    else if (!expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/disp_pwr_ctrl.sv
module disp_pwr_ctrl
  import disp_pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              wr_done,
  input  logic              wr_err,
  input  gap_e              cur_gap,
  input  logic              tmr_expired,
  output logic [STEP_W-1:0] step_idx,
  output logic              tmr_load,
  output logic              wr_stb,
  output logic              busy,
  output logic              pwr_on
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_ACK, S_GAP} st_e;

  st_e               st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              up_q, up_d;
  logic              err_q, err_d;
  logic              pwr_q, pwr_d;
  logic              last_step, fail, advance;

  assign last_step = up_q ? (step_q == STEP_W'(LAST_UP_STEP))
                          : (step_q == STEP_W'(LAST_DN_STEP));
  assign fail      = err_q || (st_q == S_ACK && wr_done && wr_err);

  assign step_idx = step_q;
  assign wr_stb   = (st_q == S_ISSUE);
  assign busy     = (st_q != S_IDLE);
  assign pwr_on   = pwr_q;

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    up_d     = up_q;
    err_d    = err_q;
    pwr_d    = pwr_q;
    tmr_load = 1'b0;
    advance  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_off && pwr_q) begin
          st_d = S_ISSUE; up_d = 1'b0; step_d = '0; err_d = 1'b0;
        end else if (req_on && !req_off && !pwr_q) begin
          st_d = S_ISSUE; up_d = 1'b1; step_d = '0; err_d = 1'b0;
        end
      end
      S_ISSUE: st_d = S_ACK;
      S_ACK: begin
        if (wr_done) begin
          err_d = fail;
          if (cur_gap != GAP_NONE) begin
            tmr_load = 1'b1;
            st_d     = S_GAP;
          end else begin
            advance = 1'b1;
          end
        end
      end
      S_GAP: if (tmr_expired) advance = 1'b1;
      default: st_d = S_IDLE;
    endcase
    if (advance) begin
      if (last_step) begin
        st_d   = S_IDLE;
        step_d = '0;
        if (!fail) pwr_d = up_q;
      end else begin
        st_d   = S_ISSUE;
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      up_q   <= 1'b0;
      err_q  <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      up_q   <= up_d;
      err_q  <= err_d;
      pwr_q  <= pwr_d;
    end
  end

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_pwr_pkg::*;
#(
  parameter longint CLK_HZ   = 200_000_000,
  parameter longint SHORT_MS = 10,
  parameter longint LONG_MS  = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_on,
  input  logic        req_off,
  input  logic        wr_done,
  input  logic        wr_err,
  output logic [7:0]  reg_idx,
  output logic [15:0] reg_val,
  output logic        wr_stb,
  output logic        busy,
  output logic        pwr_on
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [STEP_W-1:0] step_idx;
  step_t             cur;
  logic              tmr_load, tmr_expired;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  disp_pwr_steps u_steps (
    .step_idx (step_idx),
    .step     (cur)
  );

  disp_pwr_timer #(
    .CLK_HZ   (CLK_HZ),
    .SHORT_MS (SHORT_MS),
    .LONG_MS  (LONG_MS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .gap     (cur.gap),
    .expired (tmr_expired)
  );

  disp_pwr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_on      (req_on),
    .req_off     (req_off),
    .wr_done     (wr_done),
    .wr_err      (wr_err),
    .cur_gap     (cur.gap),
    .tmr_expired (tmr_expired),
    .step_idx    (step_idx),
    .tmr_load    (tmr_load),
    .wr_stb      (wr_stb),
    .busy        (busy),
    .pwr_on      (pwr_on)
  );

  assign reg_idx = cur.idx;
  assign reg_val = cur.val;

endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_on,
  input logic        req_off,
  input logic [7:0]  reg_idx,
  input logic [15:0] reg_val,
  input logic        wr_stb,
  input logic        busy,
  input logic        pwr_on
);

  // R11: strobe lasts a single cycle
  p_stb_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R11: strobe only while a program runs
  p_stb_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> busy);

  // R11: command fields move only together with a new strobe
  p_fields_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !($stable(reg_idx) && $stable(reg_val))) |-> wr_stb);

  // R12: flag moves only as busy falls
  p_flag_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_on) |-> $fell(busy));

  // R2: the extra register is written only by the power-up program
  p_extra_reg_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_idx == 8'h56) |-> !pwr_on);

  // R7: no request keeps the block idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_on && !req_off) |=> !busy);

  // R7: while on, only a power-down request can start anything
  p_on_needs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_on && !req_off) |=> !busy);

endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_on  (req_on),
  .req_off (req_off),
  .reg_idx (reg_idx),
  .reg_val (reg_val),
  .wr_stb  (wr_stb),
  .busy    (busy),
  .pwr_on  (pwr_on)
);

// File: tb/disp_pwr_seq_bench.sv
`timescale 1ns/1ps
module disp_pwr_seq_bench;

  localparam longint CLK_HZ = 50_050;
  localparam int NS = 501;   // ceil(10 * 50050 / 1000)
  localparam int NL = 2002;  // ceil(40 * 50050 / 1000)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0, wr_done = 1'b0, wr_err = 1'b0;
  logic [7:0]  reg_idx;
  logic [15:0] reg_val;
  logic wr_stb, busy, pwr_on;

  always #2.5 clk = ~clk;  // 200 MHz

  disp_pwr_seq #(.CLK_HZ(CLK_HZ)) u_disp_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .wr_done(wr_done), .wr_err(wr_err), .reg_idx(reg_idx), .reg_val(reg_val),
    .wr_stb(wr_stb), .busy(busy), .pwr_on(pwr_on)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [23:0] exp_q[$];
  logic [23:0] cur_item;
  bit     mon_en = 1'b0, holding = 1'b0, have_done = 1'b0, prev_stb = 1'b0;
  int     hold_cnt = 0, wr_no = 0, err_at = -1;
  longint last_done_cyc = 0, exp_gap = 0;

  function automatic logic [23:0] up_item(input int i);
    case (i)
      0: return {8'h10, 16'h0000};
      1: return {8'h11, 16'h0000};
      2: return {8'h12, 16'h0000};
      3: return {8'h13, 16'h0000};
      4: return {8'h56, 16'h080F};
      5: return {8'h10, 16'h4240};
      6: return {8'h11, 16'h0000};
      7: return {8'h12, 16'h0014};
      default: return {8'h13, 16'h1319};
    endcase
  endfunction

  function automatic longint gap_of(input logic [7:0] idx);
    if (idx == 8'h10) return NS + 1;                  // R4
    if (idx == 8'h12 || idx == 8'h13) return NL + 1;  // R5
    return 1;                                          // R6
  endfunction

  // monitor and write slave
  always @(negedge clk) begin
    wr_done <= 1'b0;
    wr_err  <= 1'b0;
    if (mon_en) begin
      if (wr_stb) begin
        chk(!prev_stb, "R11 strobe width", 1, 0);
        chk(exp_q.size() != 0, "R9 unexpected write", reg_idx, 0);
        if (exp_q.size() != 0) begin
          cur_item = exp_q.pop_front();
          chk({reg_idx, reg_val} == cur_item, "R2/R3 write item", {reg_idx, reg_val}, cur_item);
          if (have_done)
            chk(cyc - last_done_cyc == exp_gap, "R4/R5/R6 gap", cyc - last_done_cyc, exp_gap);
          holding  = 1'b1;
          hold_cnt = 2;
        end
      end else if (holding) begin
        chk({reg_idx, reg_val} == cur_item, "R11 fields held", {reg_idx, reg_val}, cur_item);
        hold_cnt--;
        if (hold_cnt == 0) begin
          wr_done <= 1'b1;
          wr_err  <= (wr_no == err_at);
          wr_no++;
          last_done_cyc = cyc;
          exp_gap       = gap_of(cur_item[23:16]);
          have_done     = 1'b1;
          holding       = 1'b0;
        end
      end
    end
    prev_stb = wr_stb;
  end

  task automatic pulse(input bit on, input bit off);
    @(negedge clk);
    req_on  <= on;
    req_off <= off;
    @(negedge clk);
    req_on  <= 1'b0;
    req_off <= 1'b0;
  endtask

  // Run one program. up selects which items are expected; interrupt pulses
  // the opposite request mid-program; err_write injects an error.
  task automatic run_seq(input bit up, input bit on_r, input bit off_r,
                         input bit interrupt, input int err_write, input bit exp_flag);
    int n;
    n = up ? 9 : 4;
    for (int i = 0; i < n; i++) exp_q.push_back(up_item(i));
    have_done = 1'b0;
    wr_no     = 0;
    err_at    = err_write;
    @(negedge clk);
    req_on  <= on_r;
    req_off <= off_r;
    @(negedge clk);
    req_on  <= 1'b0;
    req_off <= 1'b0;
    chk(busy == 1'b1, "R2/R3/R8 program started", busy, 1);
    if (interrupt) begin
      repeat (700) @(negedge clk);
      req_on  <= !up;
      req_off <= up;
      @(negedge clk);
      req_on  <= 1'b0;
      req_off <= 1'b0;
    end
    do @(negedge clk); while (busy);
    chk(cyc - last_done_cyc == NL + 1, "R5 final gap", cyc - last_done_cyc, NL + 1);
    chk(exp_q.size() == 0, "R2/R3 all writes issued", exp_q.size(), 0);
    chk(pwr_on == exp_flag, "R12/R10 flag after program", pwr_on, exp_flag);
    err_at = -1;
  endtask

  task automatic expect_ignored(input bit on_r, input bit off_r, input string tag);
    logic flag0;
    flag0 = pwr_on;
    pulse(on_r, off_r);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!busy && !wr_stb, tag, busy, 0);
    end
    chk(pwr_on == flag0, tag, pwr_on, flag0);
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(wr_stb == 1'b0, "R1 strobe at reset", wr_stb, 0);
    chk(pwr_on == 1'b0, "R1 flag at reset", pwr_on, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;
    chk(!busy && !pwr_on, "R1 after release", {busy, pwr_on}, 0);

    expect_ignored(1'b0, 1'b1, "R7 off while off");
    expect_ignored(1'b1, 1'b1, "R8 both while off");
    run_seq(1'b1, 1'b1, 1'b0, 1'b0, -1, 1'b1);   // R2 R4 R5 R6
    expect_ignored(1'b1, 1'b0, "R7 on while on");
    run_seq(1'b0, 1'b0, 1'b1, 1'b1, -1, 1'b0);   // R3 with R9 interruption
    expect_ignored(1'b0, 1'b1, "R9 no late effect");
    run_seq(1'b1, 1'b1, 1'b0, 1'b0, 3, 1'b0);    // R10 error on fourth write
    run_seq(1'b1, 1'b1, 1'b0, 1'b1, -1, 1'b1);   // R2 again with R9
    run_seq(1'b0, 1'b1, 1'b1, 1'b0, -1, 1'b0);   // R8 both while on
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 no stray writes", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule